// File: doc/BRIEF.md
# Dual-group ADC conversion sequencer

This block sequences a successive-approximation converter through two programmed channel lists. The regular list holds up to sixteen ranks and suits background scanning. The injected list holds up to four ranks and has priority. Each rank names a channel from 0 to 18 and carries its own 3-bit sampling-time code. For every conversion the controller drives a channel select, then a sample strobe for the chosen sampling time, then a convert strobe for a count set by the resolution. It then waits for a done pulse from the converter and takes the result.

Regular results leave on one data port with a valid strobe. Injected results land in one register per rank. Each group has its own end-of-conversion pulse and its own overrun pulse.

When an injected trigger arrives during a regular scan, the regular conversion is dropped and the injected list runs to the end. The regular scan then goes on at the rank it lost. That rank is converted again from the start of its sampling phase. An auto-inject option runs the injected list after every complete regular pass, with no injected trigger needed.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the sample and convert strobes, the channel select, all result strobes and flags, and every injected rank register are zero.
- R2: The sample strobe stays high for 3, 15, 28, 56, 84, 112, 144 or 480 cycles for sampling codes 0 to 7. The convert strobe that follows stays high for 12, 10, 8 or 6 cycles for cfg_res 0, 1, 2 or 3. The two strobes are never high together, and a convert phase always comes straight after a sample phase.
- R3: With cfg_scan high, one regular trigger converts ranks 0 through reg_len in order. Each result appears on reg_data with a one-cycle reg_valid after the converter's done pulse. With cfg_scan low, a trigger converts rank 0 only.
- R4: With cfg_cont high, the regular list starts again at rank 0 after its last rank, with no trigger. Once cfg_cont is low, the conversions stop at the end of the current pass.
- R5: reg_eoc pulses together with reg_valid. When cfg_eoc_each is high it pulses on every regular result; otherwise it pulses only on the last rank of the pass.
- R6: An injected trigger that arrives during a regular conversion drops that conversion. The injected list runs in full, and the regular scan then carries on at the dropped rank, starting again with a full sample phase. No regular result is lost, repeated or reordered.
- R7: Injected results for ranks 0 through inj_len go to inj_data, rank r at bits [r*12 +: 12]. A single inj_eoc pulse follows the result of the last rank.
- R8: With cfg_auto_inj high, the injected list runs after each complete regular pass, and its inj_eoc comes after that pass's last regular result. inj_trig is then ignored: it neither preempts nor raises an overrun.
- R9: A trigger for a group that is already running or pending is ignored and gives a one-cycle pulse on that group's overrun output (reg_ovr or inj_ovr). The group's result count does not change.
- R10: An accepted injected trigger leads to a sample phase on injected rank 0 within two clock cycles of the edge that samples the trigger.
- R11: conv_chan carries the programmed channel of the rank being converted, rank r of a list at bits [r*5 +: 5]. It holds steady through the convert phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_scan | input | 1 | Convert the whole regular list per trigger |
| cfg_cont | input | 1 | Restart the regular list after its last rank |
| cfg_auto_inj | input | 1 | Run the injected list after each regular pass |
| cfg_eoc_each | input | 1 | reg_eoc on every regular result instead of the last only |
| cfg_res | input | 2 | Resolution code: 0=12, 1=10, 2=8, 3=6 bits |
| reg_len | input | 4 | Number of regular ranks minus one |
| inj_len | input | 2 | Number of injected ranks minus one |
| reg_chan | input | 80 | Regular rank channels, 5 bits per rank |
| reg_smp | input | 48 | Regular rank sampling codes, 3 bits per rank |
| inj_chan | input | 20 | Injected rank channels, 5 bits per rank |
| inj_smp | input | 12 | Injected rank sampling codes, 3 bits per rank |
| reg_trig | input | 1 | Regular start trigger, sampled at the clock edge |
| inj_trig | input | 1 | Injected start trigger, sampled at the clock edge |
| conv_chan | output | 5 | Channel select to the converter |
| conv_sample | output | 1 | Sample-phase strobe |
| conv_convert | output | 1 | Convert-phase strobe |
| conv_done | input | 1 | Converter result-ready pulse |
| conv_result | input | 12 | Converter result |
| reg_data | output | 12 | Latest regular result |
| reg_valid | output | 1 | reg_data updated this cycle |
| reg_eoc | output | 1 | Regular end-of-conversion pulse |
| reg_ovr | output | 1 | Regular trigger ignored while busy |
| inj_data | output | 48 | Injected rank registers, 12 bits per rank |
| inj_eoc | output | 1 | Injected list complete pulse |
| inj_ovr | output | 1 | Injected trigger ignored while busy |

## Verification
The assertions check, on every cycle, the rules that hold locally: the sample and convert strobes are exclusive, a convert phase is always entered from a sample phase, the channel holds steady while converting, results and end-of-conversion pulses follow a done pulse, and overrun pulses follow a trigger. Phase lengths, rank order, the continuous restart and stop, preemption and resumption at the same rank, the auto-inject ordering and the trigger latency depend on sequences of many cycles. Only the bench's scenarios can show them, by comparing recorded strobe runs and result streams with the programmed lists.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int CNT_W = 9;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SAMP,
      PH_CONV,
      PH_WAIT
   } phase_e;

   // sampling-time code to converter clocks
   function automatic logic [CNT_W-1:0] smp_cycles(input logic [2:0] code);
      logic [CNT_W-1:0] n;
      case (code)
         3'd0:    n = 9'd3;
         3'd1:    n = 9'd15;
         3'd2:    n = 9'd28;
         3'd3:    n = 9'd56;
         3'd4:    n = 9'd84;
         3'd5:    n = 9'd112;
         3'd6:    n = 9'd144;
         default: n = 9'd480;
      endcase
      return n;
   endfunction

   // resolution code to successive-approximation clocks
   function automatic logic [CNT_W-1:0] sar_cycles(input logic [1:0] res);
      return CNT_W'(4'd12 - {1'b0, res, 1'b0});
   endfunction

endpackage

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
   parameter int N = 4,
   parameter int W = 5,
   localparam int IW = $clog2(N)
) (
   input  logic [N*W-1:0] bus,
   input  logic [IW-1:0]  idx,
   output logic [W-1:0]   y
);

   if (N < 2) begin : g_bad_n
      $error("adc_seq_pick: N must be at least 2");
   end

   logic [W-1:0] elem [N];

   for (genvar g = 0; g < N; g++) begin : g_elem
      assign elem[g] = bus[g*W +: W];
   end

   assign y = elem[idx];

endmodule

// File: rtl/adc_seq_phase.sv
module adc_seq_phase
   import adc_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [2:0] smp_code,
   input  logic [1:0] res_code,
   input  logic       conv_done,
   output logic       sampling,
   output logic       converting,
   output logic       waiting,
   output logic       fin
);

   phase_e           ph_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else if (start) begin
         ph_q  <= PH_SAMP;
         cnt_q <= smp_cycles(smp_code) - 1'b1;
      end else begin
         case (ph_q)
            PH_SAMP: begin
               if (cnt_q == '0) begin
                  ph_q  <= PH_CONV;
                  cnt_q <= sar_cycles(res_code) - 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_CONV: begin
               if (cnt_q == '0) ph_q <= PH_WAIT;
               else             cnt_q <= cnt_q - 1'b1;
            end
            PH_WAIT: begin
               if (conv_done) ph_q <= PH_IDLE;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign sampling   = (ph_q == PH_SAMP);
   assign converting = (ph_q == PH_CONV);
   assign waiting    = (ph_q == PH_WAIT);
   assign fin        = waiting & conv_done;

endmodule

// File: rtl/adc_seq_inj_bank.sv
module adc_seq_inj_bank #(
   parameter int RANKS = 4,
   parameter int DW    = 12,
   localparam int IW   = $clog2(RANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IW-1:0]     widx,
   input  logic [DW-1:0]     wdata,
   output logic [RANKS*DW-1:0] q
);

   for (genvar g = 0; g < RANKS; g++) begin : g_rank
      logic [DW-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        r_q <= '0;
         else if (we && widx == IW'(g))     r_q <= wdata;
      end
      assign q[g*DW +: DW] = r_q;
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int REG_RANKS = 16,
   parameter int INJ_RANKS = 4,
   parameter int CH_W      = 5,
   parameter int DATA_W    = 12,
   localparam int RR_W     = $clog2(REG_RANKS),
   localparam int IR_W     = $clog2(INJ_RANKS),
   localparam int SMP_W    = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_scan,
   input  logic                      cfg_cont,
   input  logic                      cfg_auto_inj,
   input  logic                      cfg_eoc_each,
   input  logic [1:0]                cfg_res,
   input  logic [RR_W-1:0]           reg_len,
   input  logic [IR_W-1:0]           inj_len,
   input  logic [REG_RANKS*CH_W-1:0] reg_chan,
   input  logic [REG_RANKS*SMP_W-1:0] reg_smp,
   input  logic [INJ_RANKS*CH_W-1:0] inj_chan,
   input  logic [INJ_RANKS*SMP_W-1:0] inj_smp,
   input  logic                      reg_trig,
   input  logic                      inj_trig,
   output logic [CH_W-1:0]           conv_chan,
   output logic                      conv_sample,
   output logic                      conv_convert,
   input  logic                      conv_done,
   input  logic [DATA_W-1:0]         conv_result,
   output logic [DATA_W-1:0]         reg_data,
   output logic                      reg_valid,
   output logic                      reg_eoc,
   output logic                      reg_ovr,
   output logic [INJ_RANKS*DATA_W-1:0] inj_data,
   output logic                      inj_eoc,
   output logic                      inj_ovr
);

   // elaboration-time parameter checks
   if (REG_RANKS < 2 || (1 << RR_W) != REG_RANKS) begin : g_bad_reg
      $error("adc_seq_ctrl: REG_RANKS must be a power of two, at least 2");
   end
   if (INJ_RANKS < 2 || (1 << IR_W) != INJ_RANKS) begin : g_bad_inj
      $error("adc_seq_ctrl: INJ_RANKS must be a power of two, at least 2");
   end
   if (CH_W < 5) begin : g_bad_ch
      $error("adc_seq_ctrl: CH_W must hold channel numbers up to 18");
   end

   // group state
   logic            reg_busy_q, inj_busy_q, cur_inj_q;
   logic [RR_W-1:0] reg_rank_q;
   logic [IR_W-1:0] inj_rank_q;

   // phase engine handshake
   logic sampling, converting, waiting, fin, eng_busy;

   // rank lookups
   logic [CH_W-1:0]  reg_ch_sel, inj_ch_sel;
   logic [SMP_W-1:0] reg_smp_sel, inj_smp_sel, start_smp;

   adc_seq_pick #(.N(REG_RANKS), .W(CH_W)) u_reg_ch (
      .bus(reg_chan), .idx(reg_rank_q), .y(reg_ch_sel));
   adc_seq_pick #(.N(REG_RANKS), .W(SMP_W)) u_reg_smp (
      .bus(reg_smp), .idx(reg_rank_q), .y(reg_smp_sel));
   adc_seq_pick #(.N(INJ_RANKS), .W(CH_W)) u_inj_ch (
      .bus(inj_chan), .idx(inj_rank_q), .y(inj_ch_sel));
   adc_seq_pick #(.N(INJ_RANKS), .W(SMP_W)) u_inj_smp (
      .bus(inj_smp), .idx(inj_rank_q), .y(inj_smp_sel));

   // trigger arbitration
   logic inj_accept, inj_reject, reg_accept, reg_reject;
   logic preempt, idle_inj, idle_reg, start_inj, start;
   logic reg_last, inj_last;

   assign eng_busy   = sampling | converting | waiting;
   assign inj_accept = inj_trig & ~cfg_auto_inj & ~inj_busy_q;
   assign inj_reject = inj_trig & ~cfg_auto_inj &  inj_busy_q;
   assign reg_accept = reg_trig & ~reg_busy_q;
   assign reg_reject = reg_trig &  reg_busy_q;

   // injected group drops a regular conversion unless its result is arriving now
   assign preempt   = inj_accept & eng_busy & ~cur_inj_q & ~fin;
   assign idle_inj  = ~eng_busy & (inj_busy_q | inj_accept);
   assign idle_reg  = ~eng_busy & ~inj_busy_q & ~inj_accept & (reg_busy_q | reg_accept);
   assign start_inj = preempt | idle_inj;
   assign start     = start_inj | idle_reg;
   assign start_smp = start_inj ? inj_smp_sel : reg_smp_sel;

   assign reg_last = ~cfg_scan | (reg_rank_q == reg_len);
   assign inj_last = (inj_rank_q == inj_len);

   adc_seq_phase u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .smp_code   (start_smp),
      .res_code   (cfg_res),
      .conv_done  (conv_done),
      .sampling   (sampling),
      .converting (converting),
      .waiting    (waiting),
      .fin        (fin)
   );

   adc_seq_inj_bank #(.RANKS(INJ_RANKS), .DW(DATA_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (fin & cur_inj_q),
      .widx  (inj_rank_q),
      .wdata (conv_result),
      .q     (inj_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_busy_q <= 1'b0;
         inj_busy_q <= 1'b0;
         cur_inj_q  <= 1'b0;
         reg_rank_q <= '0;
         inj_rank_q <= '0;
         reg_data   <= '0;
         reg_valid  <= 1'b0;
         reg_eoc    <= 1'b0;
         inj_eoc    <= 1'b0;
         reg_ovr    <= 1'b0;
         inj_ovr    <= 1'b0;
      end else begin
         reg_valid <= 1'b0;
         reg_eoc   <= 1'b0;
         inj_eoc   <= 1'b0;
         reg_ovr   <= reg_reject;
         inj_ovr   <= inj_reject;

         if (start)      cur_inj_q  <= start_inj;
         if (reg_accept) reg_busy_q <= 1'b1;
         if (inj_accept) inj_busy_q <= 1'b1;

         if (fin && cur_inj_q) begin
            if (inj_last) begin
               inj_busy_q <= 1'b0;
               inj_rank_q <= '0;
               inj_eoc    <= 1'b1;
            end else begin
               inj_rank_q <= inj_rank_q + IR_W'(1);
            end
         end

         if (fin && !cur_inj_q) begin
            reg_valid <= 1'b1;
            reg_data  <= conv_result;
            reg_eoc   <= cfg_eoc_each | reg_last;
            if (reg_last) begin
               reg_rank_q <= '0;
               reg_busy_q <= cfg_cont;
               if (cfg_auto_inj) inj_busy_q <= 1'b1;
            end else begin
               reg_rank_q <= reg_rank_q + RR_W'(1);
            end
         end
      end
   end

   assign conv_sample  = sampling;
   assign conv_convert = converting;
   assign conv_chan    = eng_busy ? (cur_inj_q ? inj_ch_sel : reg_ch_sel) : '0;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
   parameter int CH_W = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            conv_sample,
   input logic            conv_convert,
   input logic [CH_W-1:0] conv_chan,
   input logic            conv_done,
   input logic            reg_trig,
   input logic            inj_trig,
   input logic            cfg_auto_inj,
   input logic            reg_valid,
   input logic            reg_eoc,
   input logic            reg_ovr,
   input logic            inj_eoc,
   input logic            inj_ovr
);

   // R2: strobes exclusive
   a_r2_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({conv_sample, conv_convert}));

   // R2: convert entered only from sample
   a_r2_conv_after_samp: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_convert) |-> $past(conv_sample));

   // R11: channel steady while converting
   a_r11_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_convert && $past(conv_convert)) |-> $stable(conv_chan));

   // R3: regular result follows a done pulse
   a_r3_valid_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      reg_valid |-> $past(conv_done));

   // R5: end-of-conversion only with a result
   a_r5_eoc_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      reg_eoc |-> reg_valid);

   // R7: injected completion follows a done pulse, never with a regular result
   a_r7_inj_eoc_done: assert property (@(posedge clk) disable iff (!rst_n)
      inj_eoc |-> ($past(conv_done) && !reg_valid));

   // R9: overrun pulses follow a trigger
   a_r9_reg_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      reg_ovr |-> $past(reg_trig));

   // R9, R8: injected overrun never in auto-inject mode
   a_r9_inj_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      inj_ovr |-> ($past(inj_trig) && !$past(cfg_auto_inj)));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(CH_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .conv_sample  (conv_sample),
   .conv_convert (conv_convert),
   .conv_chan    (conv_chan),
   .conv_done    (conv_done),
   .reg_trig     (reg_trig),
   .inj_trig     (inj_trig),
   .cfg_auto_inj (cfg_auto_inj),
   .reg_valid    (reg_valid),
   .reg_eoc      (reg_eoc),
   .reg_ovr      (reg_ovr),
   .inj_eoc      (inj_eoc),
   .inj_ovr      (inj_ovr)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;

   localparam int RR = 16;
   localparam int IR = 4;
   localparam int CW = 5;
   localparam int DW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic            cfg_scan = 1'b1, cfg_cont = 1'b0, cfg_auto_inj = 1'b0, cfg_eoc_each = 1'b0;
   logic [1:0]      cfg_res = 2'd0;
   logic [3:0]      reg_len = '0;
   logic [1:0]      inj_len = '0;
   logic [RR*CW-1:0] reg_chan = '0;
   logic [RR*3-1:0]  reg_smp = '0;
   logic [IR*CW-1:0] inj_chan = '0;
   logic [IR*3-1:0]  inj_smp = '0;
   logic            reg_trig = 1'b0, inj_trig = 1'b0;
   logic [CW-1:0]   conv_chan;
   logic            conv_sample, conv_convert, conv_done;
   logic [DW-1:0]   conv_result;
   logic [DW-1:0]   reg_data;
   logic            reg_valid, reg_eoc, reg_ovr, inj_eoc, inj_ovr;
   logic [IR*DW-1:0] inj_data;

   adc_seq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_scan(cfg_scan), .cfg_cont(cfg_cont), .cfg_auto_inj(cfg_auto_inj),
      .cfg_eoc_each(cfg_eoc_each), .cfg_res(cfg_res),
      .reg_len(reg_len), .inj_len(inj_len),
      .reg_chan(reg_chan), .reg_smp(reg_smp), .inj_chan(inj_chan), .inj_smp(inj_smp),
      .reg_trig(reg_trig), .inj_trig(inj_trig),
      .conv_chan(conv_chan), .conv_sample(conv_sample), .conv_convert(conv_convert),
      .conv_done(conv_done), .conv_result(conv_result),
      .reg_data(reg_data), .reg_valid(reg_valid), .reg_eoc(reg_eoc), .reg_ovr(reg_ovr),
      .inj_data(inj_data), .inj_eoc(inj_eoc), .inj_ovr(inj_ovr)
   );

   function automatic logic [DW-1:0] exp_res(input logic [CW-1:0] ch);
      return DW'(int'(ch) * 97 + 300);
   endfunction

   function automatic int smp_len(input int code);
      case (code)
         0: return 3;   1: return 15;  2: return 28;  3: return 56;
         4: return 84;  5: return 112; 6: return 144; default: return 480;
      endcase
   endfunction

   function automatic int sar_len(input int res);
      return 12 - 2 * res;
   endfunction

   // converter stub: done in the cycle after the convert strobe drops
   logic cv_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cv_q <= 1'b0;
      else        cv_q <= conv_convert;
   end
   assign conv_done   = cv_q & ~conv_convert;
   assign conv_result = exp_res(conv_chan);

   // monitor
   int total = 0, bad = 0, cyc = 0;
   bit wd_hit = 0;
   logic [DW-1:0] res_q[$];
   bit eoc_q[$];
   int sch_q[$], slen_q[$], clen_q[$];
   int s_run = 0, c_run = 0, s_ch = 0;
   int inj_eoc_cnt = 0, reg_ovr_cnt = 0, inj_ovr_cnt = 0;
   int last_reg_cyc = 0, inj_eoc_cyc = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (reg_valid) begin
            res_q.push_back(reg_data);
            eoc_q.push_back(reg_eoc);
            last_reg_cyc = cyc;
         end
         if (inj_eoc) begin inj_eoc_cnt++; inj_eoc_cyc = cyc; end
         if (reg_ovr) reg_ovr_cnt++;
         if (inj_ovr) inj_ovr_cnt++;
         if (conv_sample) begin
            s_run++; s_ch = int'(conv_chan);
         end else if (s_run > 0) begin
            sch_q.push_back(s_ch); slen_q.push_back(s_run); s_run = 0;
         end
         if (conv_convert) c_run++;
         else if (c_run > 0) begin clen_q.push_back(c_run); c_run = 0; end
      end
      if (cyc > 150000 && !wd_hit) begin
         wd_hit = 1;
         total++; bad++;
         $display("FAIL watchdog (all reqs): actual=%0d cycles expected<=150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_logs();
      res_q.delete(); eoc_q.delete(); sch_q.delete(); slen_q.delete(); clen_q.delete();
      inj_eoc_cnt = 0; reg_ovr_cnt = 0; inj_ovr_cnt = 0;
   endtask

   task automatic pulse_reg();
      @(posedge clk); #1 reg_trig = 1'b1;
      @(posedge clk); #1 reg_trig = 1'b0;
   endtask

   task automatic pulse_inj();
      @(posedge clk); #1 inj_trig = 1'b1;
      @(posedge clk); #1 inj_trig = 1'b0;
   endtask

   // R10: fire injected trigger and measure start latency
   task automatic fire_inj_latency(input int ch0);
      bit seen = 0;
      pulse_inj();
      for (int k = 0; k < 2 && !seen; k++) begin
         @(negedge clk);
         if (conv_sample && int'(conv_chan) == ch0) seen = 1;
      end
      chk("R10 inj start latency", int'(seen), 1);
   endtask

   task automatic wait_quiet();
      int q = 0;
      while (q < 8) begin
         @(negedge clk);
         if (!conv_sample && !conv_convert) q++;
         else q = 0;
      end
   endtask

   task automatic set_reg(input int r, input int ch, input int code);
      reg_chan[r*CW +: CW] = CW'(ch);
      reg_smp[r*3 +: 3]    = 3'(code);
   endtask

   task automatic set_inj(input int r, input int ch, input int code);
      inj_chan[r*CW +: CW] = CW'(ch);
      inj_smp[r*3 +: 3]    = 3'(code);
   endtask

   function automatic int rch(input int r);
      return int'(reg_chan[r*CW +: CW]);
   endfunction

   function automatic int ich(input int r);
      return int'(inj_chan[r*CW +: CW]);
   endfunction

   function automatic int idat(input int r);
      return int'(inj_data[r*DW +: DW]);
   endfunction

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 sample strobe", int'(conv_sample), 0);
      chk("R1 convert strobe", int'(conv_convert), 0);
      chk("R1 channel", int'(conv_chan), 0);
      chk("R1 result flags", int'({reg_valid, reg_eoc, reg_ovr, inj_eoc, inj_ovr}), 0);
      chk("R1 inj registers", int'(inj_data == '0), 1);

      // random scan passes: R2, R3, R5, R11
      for (int it = 0; it < 8; it++) begin
         int len = $urandom_range(0, 15);
         int res = $urandom_range(0, 3);
         int each = $urandom_range(0, 1);
         cfg_res = 2'(res); cfg_eoc_each = each[0]; cfg_scan = 1'b1; cfg_cont = 1'b0;
         reg_len = 4'(len);
         for (int r = 0; r < RR; r++) set_reg(r, $urandom_range(0, 18), $urandom_range(0, 2));
         clear_logs();
         pulse_reg();
         wait_quiet();
         chk("R3 result count", res_q.size(), len + 1);
         chk("R2 sample run count", slen_q.size(), len + 1);
         for (int r = 0; r <= len && r < res_q.size() && r < slen_q.size(); r++) begin
            chk("R3 rank result", int'(res_q[r]), int'(exp_res(CW'(rch(r)))));
            chk("R5 eoc select", int'(eoc_q[r]), (each == 1 || r == len) ? 1 : 0);
            chk("R11 channel of rank", sch_q[r], rch(r));
            chk("R2 sample length", slen_q[r], smp_len(int'(reg_smp[r*3 +: 3])));
            chk("R2 convert length", clen_q[r], sar_len(res));
         end
      end

      // R3 non-scan: rank 0 only
      cfg_scan = 1'b0; reg_len = 4'd3; cfg_eoc_each = 1'b0; cfg_res = 2'd0;
      set_reg(0, 12, 0); set_reg(1, 13, 0);
      clear_logs();
      pulse_reg();
      wait_quiet();
      chk("R3 non-scan count", res_q.size(), 1);
      if (res_q.size() > 0) chk("R3 non-scan rank0", int'(res_q[0]), int'(exp_res(CW'(12))));
      if (eoc_q.size() > 0) chk("R5 non-scan eoc", int'(eoc_q[0]), 1);

      // R4 continuous restart and stop at pass end
      cfg_scan = 1'b1; cfg_cont = 1'b1; reg_len = 4'd2;
      set_reg(0, 1, 0); set_reg(1, 2, 0); set_reg(2, 3, 1);
      clear_logs();
      pulse_reg();
      while (res_q.size() < 7) @(negedge clk);
      cfg_cont = 1'b0;
      wait_quiet();
      chk("R4 whole passes", res_q.size() % 3, 0);
      chk("R4 stopped after pass", int'(res_q.size() == 9), 1);
      for (int i = 0; i < res_q.size(); i++)
         chk("R4 repeated order", int'(res_q[i]), int'(exp_res(CW'(rch(i % 3)))));

      // R6 preemption of a regular conversion in its convert phase
      reg_len = 4'd3;
      set_reg(0, 3, 1); set_reg(1, 7, 1); set_reg(2, 11, 1); set_reg(3, 15, 1);
      inj_len = 2'd1; set_inj(0, 16, 0); set_inj(1, 17, 0);
      clear_logs();
      pulse_reg();
      while (!(conv_convert && conv_chan == CW'(7))) @(negedge clk);
      fire_inj_latency(16);
      wait_quiet();
      chk("R6 regular count", res_q.size(), 4);
      for (int r = 0; r < 4 && r < res_q.size(); r++)
         chk("R6 regular order", int'(res_q[r]), int'(exp_res(CW'(rch(r)))));
      begin
         int n7 = 0, last7 = 0;
         foreach (sch_q[i]) if (sch_q[i] == 7) begin n7++; last7 = slen_q[i]; end
         chk("R6 rank resampled", n7, 2);
         chk("R6 full resample", last7, 15);
      end
      chk("R7 inj rank0", idat(0), int'(exp_res(CW'(16))));
      chk("R7 inj rank1", idat(1), int'(exp_res(CW'(17))));
      chk("R7 inj eoc once", inj_eoc_cnt, 1);

      // R7, R10 injected list from idle, all four ranks
      inj_len = 2'd3;
      set_inj(0, 0, 0); set_inj(1, 1, 1); set_inj(2, 2, 0); set_inj(3, 18, 2);
      clear_logs();
      fire_inj_latency(0);
      wait_quiet();
      for (int r = 0; r < IR; r++) chk("R7 inj rank data", idat(r), int'(exp_res(CW'(ich(r)))));
      chk("R7 inj eoc count", inj_eoc_cnt, 1);
      chk("R7 no regular result", res_q.size(), 0);

      // R8 auto-inject after a regular pass, inj_trig ignored
      cfg_auto_inj = 1'b1; reg_len = 4'd1; inj_len = 2'd1;
      set_reg(0, 9, 1); set_reg(1, 10, 1); set_inj(0, 5, 0); set_inj(1, 6, 0);
      clear_logs();
      pulse_reg();
      repeat (20) @(posedge clk);
      pulse_inj();
      wait_quiet();
      chk("R8 regular count", res_q.size(), 2);
      chk("R8 inj eoc count", inj_eoc_cnt, 1);
      chk("R8 inj rank0", idat(0), int'(exp_res(CW'(5))));
      chk("R8 inj rank1", idat(1), int'(exp_res(CW'(6))));
      chk("R8 inj after pass", int'(inj_eoc_cyc > last_reg_cyc), 1);
      chk("R8 trigger no overrun", inj_ovr_cnt, 0);
      begin
         int n10 = 0;
         foreach (sch_q[i]) if (sch_q[i] == 10) n10++;
         chk("R8 trigger no preempt", n10, 1);
      end
      cfg_auto_inj = 1'b0;

      // R9 overrun on busy groups
      reg_len = 4'd3;
      for (int r = 0; r < 4; r++) set_reg(r, r + 4, 1);
      clear_logs();
      pulse_reg();
      repeat (5) @(posedge clk);
      pulse_reg();
      wait_quiet();
      chk("R9 reg overrun", reg_ovr_cnt, 1);
      chk("R9 reg count kept", res_q.size(), 4);
      inj_len = 2'd3;
      for (int r = 0; r < 4; r++) set_inj(r, r + 8, 1);
      clear_logs();
      pulse_inj();
      repeat (3) @(posedge clk);
      pulse_inj();
      wait_quiet();
      chk("R9 inj overrun", inj_ovr_cnt, 1);
      chk("R9 inj eoc once", inj_eoc_cnt, 1);

      // R2 long sampling codes
      reg_len = 4'd1; cfg_res = 2'd3;
      set_reg(0, 16, 7); set_reg(1, 17, 4);
      clear_logs();
      pulse_reg();
      wait_quiet();
      chk("R2 480 sample", slen_q.size() > 0 ? slen_q[0] : -1, 480);
      chk("R2 84 sample", slen_q.size() > 1 ? slen_q[1] : -1, 84);
      chk("R2 6-bit convert", clen_q.size() > 0 ? clen_q[0] : -1, 6);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule